// File: doc/BRIEF.md
# Paged Memory Access Permission Checker

This block decides, for every access request that targets one core's private memories, whether the access may proceed. Three memories are covered: a program RAM, a data RAM and a level-2 RAM. Each is cut into fixed-size protection pages, and every page owns an 8-bit permission code. The code grants read, write and execute rights separately for user mode and supervisor mode. Two gate bits then say whether the core's own direct accesses, accesses from other masters, or both are admitted.

A request carries an address, an access kind, a mode flag and a flag marking it as global. Any transfer run by a DMA engine counts as global, including one that the core itself set up. When a direct core request has an address whose top byte is zero, the block treats it as a local alias and folds it onto the core's own global window. The block then finds the region and page and evaluates the page's code. It answers allow or deny one clock after the request.

A simple write port loads the permission code of one page at a time. After reset every code is zero, so every page denies until software programs it.

Top module: `mem_page_guard`

## Requirements
- R1: After reset, `resp_valid` is 0 and every page of every region denies every access.
- R2: The core window is the 16 MB whose top address byte equals `CORE_PREFIX` (default 0x10). Inside that window the regions are laid out as follows:
  - the program RAM at offset 0xE00000, as 16 pages of 2 KB (`cfg_bank` 0);
  - the data RAM at offset 0xF00000, as 16 pages of 2 KB (`cfg_bank` 1);
  - the level-2 RAM at offset 0x800000, as 32 pages of 16 KB (`cfg_bank` 2).
  
  A code written to one page governs only that page.
- R3: The permission code bits are: 0 user read, 1 user write, 2 user execute, 3 supervisor read, 4 supervisor write, 5 supervisor execute. `req_kind` 0 is read, 1 is write and 2 is execute. `req_super` 1 selects the supervisor bits.
- R4: Bit 6 of the code admits local (direct core) requests and bit 7 admits global requests (`req_global`=1). The four cases are:
  - both bits 0: everything is denied;
  - only bit 6 set: only local requests are admitted;
  - only bit 7 set: only global requests are admitted;
  - both set: local and global requests are both admitted.
- R5: A local request whose address has top byte 0x00 is treated exactly as the same address with top byte `CORE_PREFIX`.
- R6: A global request whose address has top byte 0x00 is denied. A transfer that the core itself programmed is presented with `req_global`=1 and is judged by bit 7.
- R7: An address whose top byte is neither 0x00 nor `CORE_PREFIX` is denied. So is an address in the core window that falls outside all three regions.
- R8: `req_kind` 3 is denied whatever the code.
- R9: `resp_valid` equals `req_valid` delayed by one clock, and `resp_allow` is the decision for that request. When `resp_valid` is 0, `resp_allow` is 0.
- R10: A configuration write with `cfg_bank` 3, or with a page number at or beyond the page count of the addressed region, changes no page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Permission code write strobe |
| cfg_bank | input | 2 | Region selector for the write (0 program, 1 data, 2 level-2) |
| cfg_page | input | 5 | Page number within the region |
| cfg_code | input | 8 | Permission code to store |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| req_global | input | 1 | 1 for a global access (DMA or another master) |
| resp_valid | output | 1 | Decision present, one clock after the request |
| resp_allow | output | 1 | 1 when the access is permitted |

## Verification
The main sweep loads all 256 permission codes in turn into one page of each region. Against each code it applies every combination of kind, mode, local or global origin, and aliased or full address. This separates the right bits from each other and the two gate bits from the rights. It also separates alias folding from the global-alias denial.

Pages next to a programmed page are probed to tell page indexing apart from region decoding. Addresses just past a region's end, and addresses under a foreign prefix, show the range checks. Writes with an out-of-range bank or page, and a kind-3 request, confirm that those inputs leave the outputs unchanged.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

   localparam int unsigned NUM_BANKS = 3;
   localparam int unsigned PERM_W    = 8;

   typedef enum logic [1:0] {
      KIND_READ  = 2'd0,
      KIND_WRITE = 2'd1,
      KIND_EXEC  = 2'd2,
      KIND_BAD   = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      BANK_PROG = 2'd0,
      BANK_DATA = 2'd1,
      BANK_L2   = 2'd2,
      BANK_NONE = 2'd3
   } bank_e;

   // Page permission code, bit 7 down to bit 0
   typedef struct packed {
      logic far_ok;   // admit global requests
      logic near_ok;  // admit direct core requests
      logic sx;
      logic sw;
      logic sr;
      logic ux;
      logic uw;
      logic ur;
   } perm_t;

endpackage

// File: rtl/mpg_region_match.sv
module mpg_region_match #(
   parameter int unsigned OFF_W      = 24,
   parameter int unsigned BASE       = 32'h0080_0000,
   parameter int unsigned PAGES      = 32,
   parameter int unsigned PAGE_BYTES = 16384,
   parameter int unsigned PG_W       = 5
) (
   input  logic [OFF_W-1:0] off,
   output logic             hit,
   output logic [PG_W-1:0]  page
);
   localparam int unsigned PAGE_LG = $clog2(PAGE_BYTES);
   localparam int unsigned IDX_LG  = $clog2(PAGES);
   localparam int unsigned SPAN_LG = PAGE_LG + IDX_LG;
   localparam logic [OFF_W-1:0] BASE_V = OFF_W'(BASE);

   if ((32'd1 << PAGE_LG) != PAGE_BYTES) begin : g_bad_page
      $error("page size must be a power of two");
   end
   if ((32'd1 << IDX_LG) != PAGES) begin : g_bad_count
      $error("page count must be a power of two");
   end
   if (SPAN_LG >= OFF_W) begin : g_bad_span
      $error("region larger than the core window");
   end
   if (BASE_V[SPAN_LG-1:0] != '0) begin : g_bad_align
      $error("region base not aligned to its size");
   end

   logic [IDX_LG-1:0]  idx;
   logic [PAGE_LG-1:0] unused_lo;

   assign unused_lo = off[PAGE_LG-1:0];
   assign idx       = off[SPAN_LG-1:PAGE_LG];
   assign hit       = (off[OFF_W-1:SPAN_LG] == BASE_V[OFF_W-1:SPAN_LG]);
   assign page      = PG_W'(idx);
endmodule

// File: rtl/mpg_addr_decode.sv
module mpg_addr_decode
   import mpg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned ALIAS_W     = 8,
   parameter logic [ALIAS_W-1:0] CORE_PREFIX = 8'h10,
   parameter int unsigned PG_W        = 5,
   parameter int unsigned PROG_BASE   = 32'h00E0_0000,
   parameter int unsigned PROG_PAGES  = 16,
   parameter int unsigned PROG_PAGE_B = 2048,
   parameter int unsigned DATA_BASE   = 32'h00F0_0000,
   parameter int unsigned DATA_PAGES  = 16,
   parameter int unsigned DATA_PAGE_B = 2048,
   parameter int unsigned L2_BASE     = 32'h0080_0000,
   parameter int unsigned L2_PAGES    = 32,
   parameter int unsigned L2_PAGE_B   = 16384
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_global,
   output logic              hit,
   output bank_e             bank,
   output logic [PG_W-1:0]   page
);
   localparam int unsigned OFF_W = ADDR_W - ALIAS_W;
   localparam int unsigned BASE_A  [NUM_BANKS] = '{PROG_BASE, DATA_BASE, L2_BASE};
   localparam int unsigned PAGES_A [NUM_BANKS] = '{PROG_PAGES, DATA_PAGES, L2_PAGES};
   localparam int unsigned BYTES_A [NUM_BANKS] = '{PROG_PAGE_B, DATA_PAGE_B, L2_PAGE_B};

   if (CORE_PREFIX == '0) begin : g_bad_prefix
      $error("core prefix must differ from the alias prefix");
   end

   logic [ALIAS_W-1:0] top_bits;
   logic [OFF_W-1:0]   off;
   logic               is_alias;
   logic               core_ok;
   logic [NUM_BANKS-1:0] rhit;
   logic [PG_W-1:0]      rpage [NUM_BANKS];

   assign top_bits = addr[ADDR_W-1 -: ALIAS_W];
   assign off      = addr[OFF_W-1:0];
   assign is_alias = (top_bits == '0);
   // folding: a zero prefix stands for the own prefix, but only for direct requests
   assign core_ok  = is_alias ? !is_global : (top_bits == CORE_PREFIX);

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_rgn
      mpg_region_match #(
         .OFF_W     (OFF_W),
         .BASE      (BASE_A[g]),
         .PAGES     (PAGES_A[g]),
         .PAGE_BYTES(BYTES_A[g]),
         .PG_W      (PG_W)
      ) u_match (
         .off (off),
         .hit (rhit[g]),
         .page(rpage[g])
      );
   end

   always_comb begin
      hit  = 1'b0;
      bank = BANK_NONE;
      page = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (rhit[i]) begin
            hit  = core_ok;
            bank = bank_e'(i);
            page = rpage[i];
         end
      end
   end
endmodule

// File: rtl/mpg_perm_bank.sv
module mpg_perm_bank
   import mpg_pkg::*;
#(
   parameter int unsigned PAGES = 16,
   parameter int unsigned PG_W  = 5,
   parameter bank_e       BANK  = BANK_PROG
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_bank,
   input  logic [PG_W-1:0] cfg_page,
   input  perm_t           cfg_code,
   input  logic [PG_W-1:0] rd_page,
   output perm_t           rd_code
);
   localparam int unsigned IDX_LG = $clog2(PAGES);

   if (IDX_LG > PG_W) begin : g_bad_width
      $error("page field too narrow for this region");
   end

   perm_t regs [PAGES];
   logic  bank_hit;

   assign bank_hit = cfg_we && (cfg_bank == BANK);

   for (genvar p = 0; p < PAGES; p++) begin : g_page
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[p] <= '0;
         end else if (bank_hit && (cfg_page == PG_W'(p))) begin
            regs[p] <= cfg_code;
         end
      end
   end

   logic in_rng;
   assign in_rng  = (32'(rd_page) < PAGES);
   assign rd_code = in_rng ? regs[rd_page[IDX_LG-1:0]] : '0;
endmodule

// File: rtl/mpg_rule_eval.sv
module mpg_rule_eval
   import mpg_pkg::*;
(
   input  perm_t      code,
   input  logic [1:0] kind,
   input  logic       super_mode,
   input  logic       is_global,
   output logic       allow
);
   logic gate_ok;
   logic right_ok;

   assign gate_ok = is_global ? code.far_ok : code.near_ok;

   always_comb begin
      unique case (acc_kind_e'(kind))
         KIND_READ:  right_ok = super_mode ? code.sr : code.ur;
         KIND_WRITE: right_ok = super_mode ? code.sw : code.uw;
         KIND_EXEC:  right_ok = super_mode ? code.sx : code.ux;
         default:    right_ok = 1'b0;
      endcase
   end

   assign allow = gate_ok & right_ok;
endmodule

// File: rtl/mem_page_guard.sv
module mem_page_guard
   import mpg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter logic [7:0]  CORE_PREFIX = 8'h10,
   parameter int unsigned PROG_BASE   = 32'h00E0_0000,
   parameter int unsigned PROG_PAGES  = 16,
   parameter int unsigned PROG_PAGE_B = 2048,
   parameter int unsigned DATA_BASE   = 32'h00F0_0000,
   parameter int unsigned DATA_PAGES  = 16,
   parameter int unsigned DATA_PAGE_B = 2048,
   parameter int unsigned L2_BASE     = 32'h0080_0000,
   parameter int unsigned L2_PAGES    = 32,
   parameter int unsigned L2_PAGE_B   = 16384,
   localparam int unsigned MAX_PAGES  =
      (L2_PAGES > PROG_PAGES ? (L2_PAGES > DATA_PAGES ? L2_PAGES : DATA_PAGES)
                             : (PROG_PAGES > DATA_PAGES ? PROG_PAGES : DATA_PAGES)),
   localparam int unsigned PG_W = (MAX_PAGES < 2) ? 1 : $clog2(MAX_PAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_bank,
   input  logic [PG_W-1:0]   cfg_page,
   input  logic [PERM_W-1:0] cfg_code,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_kind,
   input  logic              req_super,
   input  logic              req_global,
   output logic              resp_valid,
   output logic              resp_allow
);
   localparam int unsigned PAGES_A [NUM_BANKS] = '{PROG_PAGES, DATA_PAGES, L2_PAGES};

   if (ADDR_W <= 8) begin : g_bad_addr
      $error("address must be wider than the prefix byte");
   end

   logic            hit;
   bank_e           bank;
   logic [PG_W-1:0] page;
   perm_t           rd_code [NUM_BANKS];
   perm_t           sel_code;
   logic            rule_ok;
   logic            allow_n;

   mpg_addr_decode #(
      .ADDR_W     (ADDR_W),
      .ALIAS_W    (8),
      .CORE_PREFIX(CORE_PREFIX),
      .PG_W       (PG_W),
      .PROG_BASE  (PROG_BASE),
      .PROG_PAGES (PROG_PAGES),
      .PROG_PAGE_B(PROG_PAGE_B),
      .DATA_BASE  (DATA_BASE),
      .DATA_PAGES (DATA_PAGES),
      .DATA_PAGE_B(DATA_PAGE_B),
      .L2_BASE    (L2_BASE),
      .L2_PAGES   (L2_PAGES),
      .L2_PAGE_B  (L2_PAGE_B)
   ) u_dec (
      .addr     (req_addr),
      .is_global(req_global),
      .hit      (hit),
      .bank     (bank),
      .page     (page)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      mpg_perm_bank #(
         .PAGES(PAGES_A[b]),
         .PG_W (PG_W),
         .BANK (bank_e'(b))
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg_we  (cfg_we),
         .cfg_bank(cfg_bank),
         .cfg_page(cfg_page),
         .cfg_code(perm_t'(cfg_code)),
         .rd_page (page),
         .rd_code (rd_code[b])
      );
   end

   always_comb begin
      unique case (bank)
         BANK_PROG: sel_code = rd_code[0];
         BANK_DATA: sel_code = rd_code[1];
         BANK_L2:   sel_code = rd_code[2];
         default:   sel_code = '0;
      endcase
   end

   mpg_rule_eval u_rule (
      .code      (sel_code),
      .kind      (req_kind),
      .super_mode(req_super),
      .is_global (req_global),
      .allow     (rule_ok)
   );

   assign allow_n = req_valid & hit & rule_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_allow <= 1'b0;
      end else begin
         resp_valid <= req_valid;
         resp_allow <= allow_n;
      end
   end
endmodule

// File: rtl/mpg_guard_chk.sv
module mpg_guard_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter logic [7:0]  CORE_PREFIX = 8'h10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_kind,
   input logic              req_global,
   input logic              resp_valid,
   input logic              resp_allow
);
   logic [7:0] top_b;
   assign top_b = req_addr[ADDR_W-1 -: 8];

   // R9
   resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);

   // R9
   resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid);

   // R9
   idle_no_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> !resp_allow);

   // R8
   bad_kind_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd3) |=> !resp_allow);

   // R6
   global_alias_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_global && top_b == 8'h00) |=> !resp_allow);

   // R7
   foreign_prefix_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && top_b != 8'h00 && top_b != CORE_PREFIX) |=> !resp_allow);
endmodule

bind mem_page_guard mpg_guard_chk #(
   .ADDR_W     (ADDR_W),
   .CORE_PREFIX(CORE_PREFIX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_addr  (req_addr),
   .req_kind  (req_kind),
   .req_global(req_global),
   .resp_valid(resp_valid),
   .resp_allow(resp_allow)
);

// File: tb/sim_mem_page_guard.sv
module sim_mem_page_guard;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_bank = '0;
   logic [4:0]  cfg_page = '0;
   logic [7:0]  cfg_code = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_super = 1'b0;
   logic        req_global = 1'b0;
   logic        resp_valid;
   logic        resp_allow;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_page_guard u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_page(cfg_page), .cfg_code(cfg_code),
      .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
      .req_super(req_super), .req_global(req_global),
      .resp_valid(resp_valid), .resp_allow(resp_allow)
   );

   function automatic int pages_of(int b);
      return (b == 2) ? 32 : 16;
   endfunction

   function automatic logic [31:0] addr_of(int b, int p, bit al);
      logic [31:0] base;
      int          sz;
      case (b)
         0:       begin base = 32'h00E0_0000; sz = 2048;  end
         1:       begin base = 32'h00F0_0000; sz = 2048;  end
         default: begin base = 32'h0080_0000; sz = 16384; end
      endcase
      return base + 32'(p * sz) + 32'h24 + (al ? 32'h0 : 32'h1000_0000);
   endfunction

   // R3 R4 R5 R6 R8: model of the decision for an in-range page
   function automatic bit model(logic [7:0] c, int k, bit s, bit g, bit al);
      bit gate;
      if (g && al) return 1'b0;
      if (k == 3)  return 1'b0;
      gate = g ? c[7] : c[6];
      return gate & (s ? c[3 + k] : c[k]);
   endfunction

   task automatic cfg(int b, int p, logic [7:0] c);
      @(negedge clk);
      cfg_we = 1'b1; cfg_bank = 2'(b); cfg_page = 5'(p); cfg_code = c;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic req(logic [31:0] a, int k, bit s, bit g, bit exp, string tag);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_kind = 2'(k); req_super = s; req_global = g;
      @(negedge clk);
      req_valid = 1'b0;
      checks++;
      if (resp_valid !== 1'b1 || resp_allow !== exp) begin
         errors++;
         $display("FAIL %s addr=%h kind=%0d sup=%0d glob=%0d: got valid=%b allow=%b, expected valid=1 allow=%b",
                  tag, a, k, s, g, resp_valid, resp_allow, exp);
      end
   endtask

   task automatic all_deny(logic [31:0] a, string tag);
      for (int k = 0; k < 4; k++)
         for (int s = 0; s < 2; s++)
            for (int g = 0; g < 2; g++)
               req(a, k, s[0], g[0], 1'b0, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (resp_valid !== 1'b0 || resp_allow !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset outputs: got valid=%b allow=%b, expected 0 0", resp_valid, resp_allow);
      end
      for (int b = 0; b < 3; b++)
         for (int p = 0; p < pages_of(b); p++) begin
            req(addr_of(b, p, 1'b0), 0, 1'b1, 1'b0, 1'b0, "R1");
            req(addr_of(b, p, 1'b0), 2, 1'b0, 1'b1, 1'b0, "R1");
         end

      // R10: ignored writes (bank 3, page beyond a 16-page region)
      cfg(3, 0, 8'hFF);
      cfg(0, 16, 8'hFF);
      cfg(1, 20, 8'hFF);
      all_deny(addr_of(0, 0, 1'b0), "R10");
      all_deny(addr_of(1, 4, 1'b0), "R10");
      all_deny(addr_of(2, 0, 1'b0), "R10");

      // R9: idle cycle gives no response and no allow
      cfg(0, 3, 8'hFF);
      req(addr_of(0, 3, 1'b0), 0, 1'b0, 1'b0, 1'b1, "R9");
      @(negedge clk);
      checks++;
      if (resp_valid !== 1'b0 || resp_allow !== 1'b0) begin
         errors++;
         $display("FAIL R9 idle: got valid=%b allow=%b, expected 0 0", resp_valid, resp_allow);
      end
      cfg(0, 3, 8'h00);

      // R3 R4 R5 R6 R8: every code against every request shape, last page of each region
      for (int b = 0; b < 3; b++) begin
         int lp = pages_of(b) - 1;
         for (int c = 0; c < 256; c++) begin
            cfg(b, lp, 8'(c));
            for (int k = 0; k < 4; k++)
               for (int s = 0; s < 2; s++)
                  for (int g = 0; g < 2; g++)
                     for (int al = 0; al < 2; al++)
                        req(addr_of(b, lp, al[0]), k, s[0], g[0],
                            model(8'(c), k, s[0], g[0], al[0]), "R3/R4/R5/R6/R8");
         end
         // R2: neighbour page unaffected by a full grant on the last page
         cfg(b, lp, 8'hFF);
         all_deny(addr_of(b, lp - 1, 1'b0), "R2");
         // R2: first page of the region maps to page 0
         cfg(b, 0, 8'hFF);
         req(addr_of(b, 0, 1'b0), 1, 1'b1, 1'b1, 1'b1, "R2");
         req(addr_of(b, 0, 1'b1), 2, 1'b0, 1'b0, 1'b1, "R2");
         all_deny(addr_of(b, 1, 1'b0), "R2");
      end

      // R7: out-of-range addresses with every page fully granted at the edges
      all_deny(32'h1088_0000, "R7");
      all_deny(32'h1087_FFFF + 32'h0008_0001, "R7");
      all_deny(32'h10E0_8000, "R7");
      all_deny(32'h10F0_8000, "R7");
      all_deny(32'h10F0_8000 - 32'h0010_8000 + 32'h0001_0000, "R7");
      all_deny(32'h2080_0024, "R7");
      all_deny(32'h11E0_0024, "R7");
      all_deny(32'h0087_C024 | 32'h0100_0000, "R7");
      // R6: core-launched DMA is global: near-only page denies it, far-only admits it
      cfg(2, 5, 8'h49);
      req(addr_of(2, 5, 1'b0), 0, 1'b1, 1'b1, 1'b0, "R6");
      req(addr_of(2, 5, 1'b0), 0, 1'b1, 1'b0, 1'b1, "R6");
      cfg(2, 5, 8'h89);
      req(addr_of(2, 5, 1'b0), 0, 1'b1, 1'b1, 1'b1, "R6");
      req(addr_of(2, 5, 1'b1), 0, 1'b1, 1'b1, 1'b0, "R6");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule